// File: doc/BRIEF.md
# Multi-Channel Start and Hop Synchronization Controller

This block decides when each channel of a multi-channel tuner leaves sleep and when it adopts new oscillator frequency and phase words. It handles two kinds of event. A start event wakes an enabled channel, or realigns it if it is already running. A hop event copies the channel's pending frequency and phase words into the words the oscillator uses. Either kind of event can be raised in one of two ways. A host write to a command register raises a soft sync. One of four external sync inputs raises a pin sync.

Each event does not act at once. It loads a hold-off counter with a programmed delay, and the action happens when the countdown expires. Every channel has its own start counter and its own hop counter. Each channel picks which of the four sync inputs it watches. This lets several channels on one input, or on several chips wired to the same input, act on exactly the same cycle. The inputs pass through a two-flop synchronizer. They are then read either as rising edges or as levels.

Register map, by write address: 0x00 channel enable (bit c = channel c), 0x01 start hold-off, 0x02 hop hold-off, 0x03 soft command, 0x04 pin configuration, 0x05 pin select, 0x08+c pending frequency of channel c, 0x10+c pending phase of channel c.

Top module: `chan_sync_ctrl`

## Requirements
- R1: After reset every channel is asleep, no start or hop pulse is asserted, and every active frequency and phase word is zero.
- R2: A write to address 0x03 with bit 0 set and channel mask bits [8+c] loads each masked channel's start counter with the value at address 0x01. Exactly N cycles after the write edge, each masked enabled channel gives a one-cycle start_pulse, and its chan_active bit goes high on that same edge.
- R3: A start event has no effect on a channel whose bit at address 0x00 is 0: that channel gives no pulse and stays asleep.
- R4: A hold-off value of 0 never launches a countdown. A start or hop request made while the matching hold-off register is 0 does nothing.
- R5: A soft command acts once. Each write launches exactly one event per masked channel, and no further pulse follows until a new write is made.
- R6: A new trigger while a countdown is running restarts that countdown from the full hold-off value. Only one pulse follows, N cycles after the last trigger.
- R7: Pending frequency and phase words (addresses 0x08+c and 0x10+c) do not change the freq_word or phase_word outputs until a hop countdown expires. On that edge the channel's words are copied and its hop_pulse is high for one cycle. A soft hop uses address 0x03 bit 1 with the same channel mask.
- R8: In pin sync, channel c watches the input whose number is in address 0x05 bits [2c+1:2c]. An input acts only if its enable bit at address 0x04 bits [4+p] is set. Start triggering needs bit 0 of address 0x04, and hop triggering needs bit 1. The counter loads two cycles after the pin change is captured, so the pulse comes N+2 cycles after that capture.
- R9: With address 0x04 bit 2 set (edge mode), only a rising edge of the synchronized input is an event. An input held high gives no further events.
- R10: With address 0x04 bit 2 clear (level mode), a high synchronized input is an event whenever the channel's matching counter is idle, even without an edge.
- R11: Writing 0 to a channel's bit at address 0x00 puts that channel to sleep: chan_active falls within two cycles of the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronized inside |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register write address |
| wr_data | input | 32 | Register write data |
| sync_pin | input | 4 | External sync inputs, asynchronous |
| chan_active | output | NCH | Per-channel awake flag |
| start_pulse | output | NCH | One-cycle start/realign pulse per channel |
| hop_pulse | output | NCH | One-cycle hop pulse per channel |
| freq_word | output | NCH*32 | Active frequency words, channel c at [32c+31:32c] |
| phase_word | output | NCH*16 | Active phase words, channel c at [16c+15:16c] |

## Verification
Soft starts are tried with masks that include a disabled channel, with a hold-off of 1 and with a hold-off of 0. This separates the enable gating, the shortest latency and the zero-value guard. A soft command repeated mid-count shows whether the counter restarts or fires twice. Pin sync is driven with one input shared by two channels and held high in edge mode, which shows the edge detector gives one event only. Pin changes on disabled inputs must give no event. Level mode is shown by enabling it while an input is already high, which only a level detector can act on. A scoreboard compares every pulse with its expected cycle and channel mask.

// File: rtl/chan_sync_pkg.sv
package chan_sync_pkg;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 32;
  localparam int NPIN   = 4;
  localparam int SEL_W  = 2;

  localparam logic [ADDR_W-1:0] A_CHAN_EN    = 5'h00;
  localparam logic [ADDR_W-1:0] A_START_HOLD = 5'h01;
  localparam logic [ADDR_W-1:0] A_HOP_HOLD   = 5'h02;
  localparam logic [ADDR_W-1:0] A_SOFT_CMD   = 5'h03;
  localparam logic [ADDR_W-1:0] A_PIN_CFG    = 5'h04;
  localparam logic [ADDR_W-1:0] A_PIN_SEL    = 5'h05;
  localparam logic [ADDR_W-1:0] A_FREQ_BASE  = 5'h08;
  localparam logic [ADDR_W-1:0] A_PHASE_BASE = 5'h10;

  localparam int SOFT_MASK_LSB = 8;
  localparam int PIN_EN_LSB    = 4;

  typedef struct packed {
    logic            start_en;
    logic            hop_en;
    logic            edge_mode;
    logic [NPIN-1:0] pin_en;
  } pin_cfg_t;
endpackage

// File: rtl/chan_sync_pin_detect.sv
module chan_sync_pin_detect #(
  parameter int NPIN = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] pin_in,
  output logic [NPIN-1:0] lvl,
  output logic [NPIN-1:0] rise
);
  logic [NPIN-1:0] meta_q, meta_d;
  logic [NPIN-1:0] sync_q, sync_d;
  logic [NPIN-1:0] prev_q, prev_d;

  always_comb begin
    meta_d = pin_in;
    sync_d = meta_q;
    prev_d = sync_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= meta_d;
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign lvl  = sync_q;
  assign rise = sync_q & ~prev_q;
endmodule

// File: rtl/chan_sync_holdoff.sv
module chan_sync_holdoff #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             fire,
  output logic             idle
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)
      cnt_d = load_val;
    else if (cnt_q != '0)
      cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign fire = (cnt_q == CNT_W'(1));
  assign idle = (cnt_q == '0);
endmodule

// File: rtl/chan_sync_regs.sv
module chan_sync_regs
  import chan_sync_pkg::*;
#(
  parameter int NCH     = 4,
  parameter int CNT_W   = 16,
  parameter int FREQ_W  = 32,
  parameter int PHASE_W = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [DATA_W-1:0]      wr_data,
  output logic [NCH-1:0]         chan_en,
  output logic [CNT_W-1:0]       start_hold,
  output logic [CNT_W-1:0]       hop_hold,
  output pin_cfg_t               pin_cfg,
  output logic [NCH*SEL_W-1:0]   pin_sel,
  output logic [NCH*FREQ_W-1:0]  freq_pend,
  output logic [NCH*PHASE_W-1:0] phase_pend,
  output logic [NCH-1:0]         soft_start,
  output logic [NCH-1:0]         soft_hop
);
  logic [NCH-1:0]         en_q, en_d;
  logic [CNT_W-1:0]       sh_q, sh_d, hh_q, hh_d;
  pin_cfg_t               cfg_q, cfg_d;
  logic [NCH*SEL_W-1:0]   sel_q, sel_d;
  logic [NCH*FREQ_W-1:0]  fp_q, fp_d;
  logic [NCH*PHASE_W-1:0] pp_q, pp_d;
  logic                   cmd_wr;

  always_comb begin
    en_d  = en_q;
    sh_d  = sh_q;
    hh_d  = hh_q;
    cfg_d = cfg_q;
    sel_d = sel_q;
    fp_d  = fp_q;
    pp_d  = pp_q;
    if (wr_en) begin
      if (wr_addr == A_CHAN_EN)    en_d = wr_data[NCH-1:0];
      if (wr_addr == A_START_HOLD) sh_d = wr_data[CNT_W-1:0];
      if (wr_addr == A_HOP_HOLD)   hh_d = wr_data[CNT_W-1:0];
      if (wr_addr == A_PIN_SEL)    sel_d = wr_data[NCH*SEL_W-1:0];
      if (wr_addr == A_PIN_CFG) begin
        cfg_d.start_en  = wr_data[0];
        cfg_d.hop_en    = wr_data[1];
        cfg_d.edge_mode = wr_data[2];
        cfg_d.pin_en    = wr_data[PIN_EN_LSB +: NPIN];
      end
      for (int c = 0; c < NCH; c++) begin
        if (wr_addr == A_FREQ_BASE + ADDR_W'(c))
          fp_d[c*FREQ_W +: FREQ_W] = wr_data[FREQ_W-1:0];
        if (wr_addr == A_PHASE_BASE + ADDR_W'(c))
          pp_d[c*PHASE_W +: PHASE_W] = wr_data[PHASE_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      sh_q  <= '0;
      hh_q  <= '0;
      cfg_q <= '0;
      sel_q <= '0;
      fp_q  <= '0;
      pp_q  <= '0;
    end else begin
      en_q  <= en_d;
      sh_q  <= sh_d;
      hh_q  <= hh_d;
      cfg_q <= cfg_d;
      sel_q <= sel_d;
      fp_q  <= fp_d;
      pp_q  <= pp_d;
    end
  end

  // Soft command is a strobe: nothing is stored, so each write arms once.
  assign cmd_wr     = wr_en && (wr_addr == A_SOFT_CMD);
  assign soft_start = (cmd_wr && wr_data[0]) ? wr_data[SOFT_MASK_LSB +: NCH] : '0;
  assign soft_hop   = (cmd_wr && wr_data[1]) ? wr_data[SOFT_MASK_LSB +: NCH] : '0;

  assign chan_en    = en_q;
  assign start_hold = sh_q;
  assign hop_hold   = hh_q;
  assign pin_cfg    = cfg_q;
  assign pin_sel    = sel_q;
  assign freq_pend  = fp_q;
  assign phase_pend = pp_q;
endmodule

// File: rtl/chan_sync_ctrl.sv
module chan_sync_ctrl
  import chan_sync_pkg::*;
#(
  parameter int NCH     = 4,
  parameter int CNT_W   = 16,
  parameter int FREQ_W  = 32,
  parameter int PHASE_W = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [4:0]             wr_addr,
  input  logic [31:0]            wr_data,
  input  logic [3:0]             sync_pin,
  output logic [NCH-1:0]         chan_active,
  output logic [NCH-1:0]         start_pulse,
  output logic [NCH-1:0]         hop_pulse,
  output logic [NCH*FREQ_W-1:0]  freq_word,
  output logic [NCH*PHASE_W-1:0] phase_word
);
  logic rst_meta_q, rst_sync_q, rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end
  assign rst_i_n = rst_sync_q;

  logic [NCH-1:0]         chan_en, soft_start, soft_hop;
  logic [CNT_W-1:0]       start_hold, hop_hold;
  pin_cfg_t               pin_cfg;
  logic [NCH*SEL_W-1:0]   pin_sel;
  logic [NCH*FREQ_W-1:0]  freq_pend;
  logic [NCH*PHASE_W-1:0] phase_pend;
  logic [NPIN-1:0]        pin_lvl, pin_rise;

  chan_sync_regs #(
    .NCH(NCH), .CNT_W(CNT_W), .FREQ_W(FREQ_W), .PHASE_W(PHASE_W)
  ) regs_i (
    .clk(clk), .rst_n(rst_i_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .chan_en(chan_en), .start_hold(start_hold), .hop_hold(hop_hold),
    .pin_cfg(pin_cfg), .pin_sel(pin_sel),
    .freq_pend(freq_pend), .phase_pend(phase_pend),
    .soft_start(soft_start), .soft_hop(soft_hop)
  );

  chan_sync_pin_detect #(.NPIN(NPIN)) pins_i (
    .clk(clk), .rst_n(rst_i_n), .pin_in(sync_pin),
    .lvl(pin_lvl), .rise(pin_rise)
  );

  logic [NCH-1:0] st_load, st_fire, st_idle;
  logic [NCH-1:0] hp_load, hp_fire, hp_idle;
  logic [NCH-1:0] pin_hit;
  logic           st_hold_ok, hp_hold_ok;

  assign st_hold_ok = (start_hold != '0);
  assign hp_hold_ok = (hop_hold != '0);

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      logic [SEL_W-1:0] sel;
      sel        = pin_sel[c*SEL_W +: SEL_W];
      pin_hit[c] = pin_cfg.pin_en[sel] &
                   (pin_cfg.edge_mode ? pin_rise[sel] : pin_lvl[sel]);
      st_load[c] = st_hold_ok & (soft_start[c] |
                   (pin_cfg.start_en & pin_hit[c] & (pin_cfg.edge_mode | st_idle[c])));
      hp_load[c] = hp_hold_ok & (soft_hop[c] |
                   (pin_cfg.hop_en & pin_hit[c] & (pin_cfg.edge_mode | hp_idle[c])));
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    chan_sync_holdoff #(.CNT_W(CNT_W)) start_cnt_i (
      .clk(clk), .rst_n(rst_i_n), .load(st_load[c]), .load_val(start_hold),
      .fire(st_fire[c]), .idle(st_idle[c])
    );
    chan_sync_holdoff #(.CNT_W(CNT_W)) hop_cnt_i (
      .clk(clk), .rst_n(rst_i_n), .load(hp_load[c]), .load_val(hop_hold),
      .fire(hp_fire[c]), .idle(hp_idle[c])
    );
  end

  logic [NCH-1:0]         act_q, act_d, stp_q, stp_d, hpp_q, hpp_d;
  logic [NCH*FREQ_W-1:0]  fw_q, fw_d;
  logic [NCH*PHASE_W-1:0] pw_q, pw_d;

  always_comb begin
    act_d = chan_en & (act_q | st_fire);
    stp_d = chan_en & st_fire;
    hpp_d = hp_fire;
    fw_d  = fw_q;
    pw_d  = pw_q;
    for (int c = 0; c < NCH; c++) begin
      if (hp_fire[c]) begin
        fw_d[c*FREQ_W +: FREQ_W]   = freq_pend[c*FREQ_W +: FREQ_W];
        pw_d[c*PHASE_W +: PHASE_W] = phase_pend[c*PHASE_W +: PHASE_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      act_q <= '0;
      stp_q <= '0;
      hpp_q <= '0;
      fw_q  <= '0;
      pw_q  <= '0;
    end else begin
      act_q <= act_d;
      stp_q <= stp_d;
      hpp_q <= hpp_d;
      fw_q  <= fw_d;
      pw_q  <= pw_d;
    end
  end

  assign chan_active = act_q;
  assign start_pulse = stp_q;
  assign hop_pulse   = hpp_q;
  assign freq_word   = fw_q;
  assign phase_word  = pw_q;
endmodule

// File: rtl/chan_sync_ctrl_chk.sv
module chan_sync_ctrl_chk
  import chan_sync_pkg::*;
#(
  parameter int NCH     = 4,
  parameter int FREQ_W  = 32,
  parameter int PHASE_W = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   wr_en,
  input logic [4:0]             wr_addr,
  input logic [31:0]            wr_data,
  input logic [NCH-1:0]         chan_active,
  input logic [NCH-1:0]         start_pulse,
  input logic [NCH-1:0]         hop_pulse,
  input logic [NCH*FREQ_W-1:0]  freq_word,
  input logic [NCH*PHASE_W-1:0] phase_word
);
  // R3: a start pulse only appears on a channel that is awake.
  assert_start_on_awake_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (start_pulse & ~chan_active) == '0);

  // R7: active words move only on a hop pulse edge.
  assert_freq_on_hop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(freq_word) |-> (hop_pulse != '0));

  assert_phase_on_hop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(phase_word) |-> (hop_pulse != '0));

  // R11: a zero enable bit puts the channel to sleep within two cycles.
  assert_sleep_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_CHAN_EN) |-> ##2
    ((chan_active & ~$past(wr_data[NCH-1:0], 2)) == '0));

  for (genvar c = 0; c < NCH; c++) begin : g_wake
    // R2: waking up is always accompanied by a start pulse.
    assert_wake_has_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(chan_active[c]) |-> start_pulse[c]);
  end
endmodule

bind chan_sync_ctrl chan_sync_ctrl_chk #(
  .NCH(NCH), .FREQ_W(FREQ_W), .PHASE_W(PHASE_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .chan_active(chan_active), .start_pulse(start_pulse), .hop_pulse(hop_pulse),
  .freq_word(freq_word), .phase_word(phase_word)
);

// File: tb/chan_sync_ctrl_tb_top.sv
`timescale 1ns/1ps
module chan_sync_ctrl_tb_top;
  localparam int NCH = 4;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                wr_en = 1'b0;
  logic [4:0]          wr_addr = '0;
  logic [31:0]         wr_data = '0;
  logic [3:0]          sync_pin = '0;
  logic [NCH-1:0]      chan_active, start_pulse, hop_pulse;
  logic [NCH*32-1:0]   freq_word;
  logic [NCH*16-1:0]   phase_word;

  always #2.5 clk = ~clk;

  chan_sync_ctrl #(.NCH(NCH)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sync_pin(sync_pin), .chan_active(chan_active), .start_pulse(start_pulse),
    .hop_pulse(hop_pulse), .freq_word(freq_word), .phase_word(phase_word)
  );

  int cyc = 0;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    bit             hop;
    logic [NCH-1:0] mask;
    int             at;
    string          req;
  } exp_t;
  exp_t sb[$];

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic expect_pulse(input bit hop, input logic [NCH-1:0] mask, input int at,
                              input string req);
    exp_t e;
    e.hop = hop; e.mask = mask; e.at = at; e.req = req;
    sb.push_back(e);
  endtask

  task automatic mon_one(input bit hop, input logic [NCH-1:0] seen);
    exp_t e;
    checks++;
    if (sb.size() == 0) begin
      failures++;
      $display("FAIL R5 unexpected %s pulse actual=%b expected=none (cycle %0d)",
               hop ? "hop" : "start", seen, cyc);
    end else begin
      e = sb.pop_front();
      if (e.hop != hop || e.mask != seen || e.at != cyc) begin
        failures++;
        $display("FAIL %s actual=%s/%b@%0d expected=%s/%b@%0d", e.req,
                 hop ? "hop" : "start", seen, cyc,
                 e.hop ? "hop" : "start", e.mask, e.at);
      end
    end
  endtask

  // Monitor: compares each observed pulse against the scoreboard head.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (start_pulse != '0) mon_one(1'b0, start_pulse);
      if (hop_pulse != '0)   mon_one(1'b1, hop_pulse);
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d, output int t);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    t = cyc;
  endtask

  task automatic raise_pin(input int p, output int t);
    @(negedge clk);
    sync_pin[p] = 1'b1;
    @(negedge clk);
    t = cyc;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drain(input string req);
    int guard = 0;
    while (sb.size() != 0 && guard < 100) begin
      @(negedge clk);
      guard++;
    end
    check(req, 64'(sb.size()), 64'd0);
    sb.delete();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int t, t1;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    idle(4);

    // R1 reset state
    check("R1 active",  64'(chan_active), 64'd0);
    check("R1 pulses",  64'({start_pulse, hop_pulse}), 64'd0);
    check("R1 freq",    64'(freq_word[63:0]), 64'd0);
    check("R1 phase",   64'(phase_word), 64'd0);

    // R2/R3: soft start on ch0..2, ch2 disabled
    wr(5'h00, 32'h3, t);
    wr(5'h01, 32'd5, t);
    wr(5'h03, 32'h0701, t);
    expect_pulse(1'b0, 4'b0011, t + 5, "R2 soft start");
    drain("R2 pulse seen");
    check("R3 disabled ch2 stays asleep", 64'(chan_active), 64'h3);

    // R4: zero hold-off never launches
    wr(5'h00, 32'h7, t);
    wr(5'h01, 32'd0, t);
    wr(5'h03, 32'h0401, t);
    idle(12);
    check("R4 zero hold-off", 64'(chan_active), 64'h3);

    // R2 boundary N=1, R5 one-shot
    wr(5'h01, 32'd1, t);
    wr(5'h03, 32'h0401, t);
    expect_pulse(1'b0, 4'b0100, t + 1, "R2 hold-off of one");
    drain("R2 short pulse seen");
    idle(20);
    check("R5 single wake", 64'(chan_active), 64'h7);

    // R6: retrigger restarts the countdown
    wr(5'h00, 32'hF, t);
    wr(5'h01, 32'd10, t);
    wr(5'h03, 32'h0801, t1);
    idle(3);
    wr(5'h03, 32'h0801, t);
    expect_pulse(1'b0, 4'b1000, t + 10, "R6 restart");
    drain("R6 pulse seen");
    check("R6 ch3 awake", 64'(chan_active), 64'hF);

    // R7: soft hop applies pending words only at expiry
    wr(5'h09, 32'h12345678, t);
    wr(5'h11, 32'h0000ABCD, t);
    wr(5'h02, 32'd3, t);
    idle(2);
    check("R7 freq held pending", 64'(freq_word[63:32]), 64'd0);
    wr(5'h03, 32'h0202, t);
    expect_pulse(1'b1, 4'b0010, t + 3, "R7 soft hop");
    drain("R7 hop seen");
    check("R7 freq ch1", 64'(freq_word[63:32]), 64'h12345678);
    check("R7 phase ch1", 64'(phase_word[31:16]), 64'hABCD);
    check("R7 freq ch0 unchanged", 64'(freq_word[31:0]), 64'd0);

    // R8/R9: edge pin sync, ch0/ch1 on pin 2, ch2 on pin 0, ch3 on pin 1
    wr(5'h05, 32'h4A, t);
    wr(5'h01, 32'd6, t);
    wr(5'h04, 32'h45, t);
    raise_pin(2, t);
    expect_pulse(1'b0, 4'b0011, t + 2 + 6, "R8 pin start");
    drain("R8 pin pulse seen");
    idle(30);
    check("R9 held pin gives one event", 64'(sb.size()), 64'd0);

    // R8: disabled pins do nothing
    raise_pin(0, t);
    raise_pin(1, t);
    idle(20);
    check("R8 disabled pins quiet", 64'(chan_active), 64'hF);

    // R10: level mode acts on an input already high
    wr(5'h0A, 32'hCAFE0001, t);
    wr(5'h12, 32'h00001357, t);
    wr(5'h02, 32'd4, t);
    wr(5'h04, 32'h12, t);
    expect_pulse(1'b1, 4'b0100, t + 1 + 4, "R10 level hop");
    wr(5'h04, 32'h00, t1);
    drain("R10 level hop seen");
    check("R10 freq ch2", 64'(freq_word[95:64]), 64'hCAFE0001);
    check("R10 phase ch2", 64'(phase_word[47:32]), 64'h1357);

    // R11: sleep by clearing enable bit
    wr(5'h00, 32'hE, t);
    idle(3);
    check("R11 ch0 asleep", 64'(chan_active), 64'hE);

    idle(10);
    check("R5 no stray events", 64'(sb.size()), 64'd0);
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule